// File: doc/BRIEF.md
# Subtractive Greatest-Common-Divisor Engine

This block finds the greatest common divisor of two unsigned `W`-bit operands by repeated subtraction. It is split into a sequencing controller and a datapath. The datapath holds two working registers, each fed through a two-way selector that picks either the external operand or a subtraction result. It also holds a result register, an inequality comparator, a less-than comparator and one subtractor for each direction. The controller is a thirteen-state binary-coded machine with fixed state codes. It drives a separate select and load line for every datapath register.

While `start` is low, the engine idles in a two-state wait loop. Once it sees `start` high, it captures `opa` and then `opb` on successive clocks. It then loops, subtracting the smaller working value from the larger, until the two are equal. That value is copied into the result register. The engine then returns to its wait loop, and `result` holds the value until the next capture. Each register write becomes visible only on the following clock. For this reason every branch that depends on a freshly written register is preceded by an empty join state.

Top module: `gcd_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the engine returns to its idle state (code 0000) and `result` is cleared to 0.
- R2: In the wait state (code 0001), a low `start` moves the engine to the wait-join state (code 0010), which returns to the wait state. While `start` stays low, neither operand is captured and `result` keeps its value.
- R3: When the wait state sees `start` high, `opa` is captured on the next clock and `opb` on the clock after that. With equal operands and `start` held high from reset release, `result` shows the answer after exactly six rising edges.
- R4: The compare state (code 0101) goes to the order-test state (code 0110) when the working values differ, and to the done state (code 1011) when they are equal.
- R5: The order test replaces the second working value by (second − first) when first < second. Otherwise it replaces the first by (first − second). Each subtraction iteration adds exactly five clocks before the next compare.
- R6: `result` is loaded only from the done state, with the first working value, and only when the two working values are equal. For nonzero operands it equals their greatest common divisor. Two zero operands give 0.
- R7: `result` changes only on the clock edge that ends the done state. While `start` is held high with unchanged operands, `result` stays constant across repeated runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Level request; sampled only in the wait state |
| opa | input | W | First unsigned operand |
| opb | input | W | Second unsigned operand |
| result | output | W | Last computed divisor; 0 after reset |

## Verification
The properties take for granted that `start`, `opa` and `opb` change synchronously. They also assume the operands are either both nonzero or both zero, because a single zero operand makes the subtraction loop run forever. The stimulus draws operands from 1 to 2^W−1, plus one directed both-zero case. New operands are presented only after `start` has been low long enough for the engine to settle back into its wait loop. This way a half-captured operand pair never occurs, and the expected answer is a clean function of the presented pair.

// File: rtl/gcd_pkg.sv
// gcd_pkg: shared state encoding and control bundle for the GCD engine.
// Assumes a 4-bit binary state register; the codes are fixed because
// the controller decodes them directly.
package gcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'b0000,
        ST_WAIT     = 4'b0001,
        ST_WAIT_J   = 4'b0010,
        ST_LD_A     = 4'b0011,
        ST_LD_B     = 4'b0100,
        ST_TEST_NE  = 4'b0101,
        ST_TEST_LT  = 4'b0110,
        ST_SUB_B    = 4'b0111,
        ST_SUB_A    = 4'b1000,
        ST_JOIN_LT  = 4'b1001,
        ST_JOIN_NE  = 4'b1010,
        ST_DONE     = 4'b1011,
        ST_JOIN_TOP = 4'b1100
    } state_t;

    // Datapath control lines: select 0 = external operand, 1 = difference
    typedef struct packed {
        logic a_sel;
        logic a_ld;
        logic b_sel;
        logic b_ld;
        logic r_ld;
    } ctl_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/gcd_ctrl.sv
// gcd_ctrl: thirteen-state sequencer for the subtractive GCD engine.
// Assumes the comparator flags reflect the current working registers.
// Every control line not set by a state is driven low; codes 1101..1111
// fall back to idle.
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   ne_flag,
    input  logic   lt_flag,
    output state_t state,
    output ctl_t   ctl
);

    state_t state_d;

    // Next-state selection following the fixed flow
    always_comb begin
        case (state)
            ST_IDLE:     state_d = ST_WAIT;
            ST_WAIT:     state_d = start ? ST_LD_A : ST_WAIT_J;
            ST_WAIT_J:   state_d = ST_WAIT;
            ST_LD_A:     state_d = ST_LD_B;
            ST_LD_B:     state_d = ST_TEST_NE;
            ST_TEST_NE:  state_d = ne_flag ? ST_TEST_LT : ST_DONE;
            ST_TEST_LT:  state_d = lt_flag ? ST_SUB_B : ST_SUB_A;
            ST_SUB_B:    state_d = ST_JOIN_LT;
            ST_SUB_A:    state_d = ST_JOIN_LT;
            ST_JOIN_LT:  state_d = ST_JOIN_NE;
            ST_JOIN_NE:  state_d = ST_TEST_NE;
            ST_DONE:     state_d = ST_JOIN_TOP;
            ST_JOIN_TOP: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Per-state control decode; unlisted lines stay low
    always_comb begin
        ctl = '0;
        case (state)
            ST_LD_A: begin ctl.a_sel = 1'b0; ctl.a_ld = 1'b1; end
            ST_LD_B: begin ctl.b_sel = 1'b0; ctl.b_ld = 1'b1; end
            ST_SUB_B: begin ctl.b_sel = 1'b1; ctl.b_ld = 1'b1; end
            ST_SUB_A: begin ctl.a_sel = 1'b1; ctl.a_ld = 1'b1; end
            ST_DONE:  ctl.r_ld = 1'b1;
            default:  ctl = '0;
        endcase
    end

endmodule

// File: rtl/gcd_opreg.sv
// gcd_opreg: one working register with its two-way input selector.
// Assumes sel=0 picks the external operand and sel=1 the difference;
// the register holds when ld is low.
module gcd_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         ld,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] diff_val,
    output logic [W-1:0] q
);

    logic [W-1:0] mux_out;

    // Input selector in front of the register
    always_comb mux_out = sel ? diff_val : ext_val;

    // Load-enabled storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= mux_out;
    end

endmodule

// File: rtl/gcd_dpath.sv
// gcd_dpath: working registers, comparators, subtractors and result
// register. Assumes control lines come from gcd_ctrl. Flags are pure
// combinational unsigned comparisons of the current register contents.
module gcd_dpath
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_t         ctl,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         ne_flag,
    output logic         lt_flag,
    output logic [W-1:0] a_val,
    output logic [W-1:0] b_val,
    output logic [W-1:0] result
);

    logic [W-1:0] lane_ext  [NUM_LANES];
    logic [W-1:0] lane_diff [NUM_LANES];
    logic         lane_sel  [NUM_LANES];
    logic         lane_ld   [NUM_LANES];
    logic [W-1:0] lane_q    [NUM_LANES];

    // Lane wiring: lane 0 is the first working value, lane 1 the second
    always_comb begin
        lane_ext[0]  = opa;
        lane_ext[1]  = opb;
        lane_diff[0] = lane_q[0] - lane_q[1];
        lane_diff[1] = lane_q[1] - lane_q[0];
        lane_sel[0]  = ctl.a_sel;
        lane_sel[1]  = ctl.b_sel;
        lane_ld[0]   = ctl.a_ld;
        lane_ld[1]   = ctl.b_ld;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        gcd_opreg #(.W(W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (lane_sel[g]),
            .ld       (lane_ld[g]),
            .ext_val  (lane_ext[g]),
            .diff_val (lane_diff[g]),
            .q        (lane_q[g])
        );
    end

    // Comparator flags for the controller
    always_comb begin
        a_val   = lane_q[0];
        b_val   = lane_q[1];
        ne_flag = (lane_q[0] != lane_q[1]);
        lt_flag = (lane_q[0] <  lane_q[1]);
    end

    // Result register, captures the first working value
    always_ff @(posedge clk) begin
        if (!rst_n)         result <= '0;
        else if (ctl.r_ld)  result <= lane_q[0];
    end

endmodule

// File: rtl/gcd_engine.sv
// gcd_engine: top of the subtractive GCD processor; joins controller
// and datapath. Assumes operands stay stable from the wait state
// through both capture states.
module gcd_engine
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result
);

    state_t       state_cur;
    ctl_t         ctl;
    logic         ne_flag;
    logic         lt_flag;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;
    logic         r_ld;

    gcd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ne_flag (ne_flag),
        .lt_flag (lt_flag),
        .state   (state_cur),
        .ctl     (ctl)
    );

    gcd_dpath #(.W(W)) u_dpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .opa     (opa),
        .opb     (opb),
        .ne_flag (ne_flag),
        .lt_flag (lt_flag),
        .a_val   (a_val),
        .b_val   (b_val),
        .result  (result)
    );

    // Capture strobe brought out for the bound checker
    always_comb r_ld = ctl.r_ld;

endmodule

// File: rtl/gcd_engine_chk.sv
// gcd_engine_chk: temporal properties of the GCD engine, bound to the top.
// Assumes operands are both nonzero or both zero.
module gcd_engine_chk
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input state_t       state_cur,
    input logic [W-1:0] a_val,
    input logic [W-1:0] b_val,
    input logic         r_ld,
    input logic [W-1:0] result
);

    // R2
    wait_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_cur == ST_WAIT && !start) |=> (state_cur == ST_WAIT_J));

    // R4
    ne_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_cur == ST_TEST_NE && a_val != b_val) |=> (state_cur == ST_TEST_LT));

    // R4
    eq_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_cur == ST_TEST_NE && a_val == b_val) |=> (state_cur == ST_DONE));

    // R5
    sub_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_cur == ST_SUB_A) |=> (a_val == $past(a_val) - $past(b_val)));

    // R5
    sub_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_cur == ST_SUB_B) |=> (b_val == $past(b_val) - $past(a_val)));

    // R6
    capture_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_ld |-> (a_val == b_val));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ld && rst_n) |=> $stable(result));

endmodule

bind gcd_engine gcd_engine_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .state_cur (state_cur),
    .a_val     (a_val),
    .b_val     (b_val),
    .r_ld      (r_ld),
    .result    (result)
);

// File: tb/gcd_engine_tb_top.sv
// gcd_engine_tb_top: seeded random plus directed stimulus, checked
// against a bench-side reference divisor.
module gcd_engine_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int prev_a = 12;
    int prev_b = 12;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gcd_engine #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opa(opa), .opb(opb), .result(result)
    );

    function automatic int ref_gcd(int a, int b);
        while (a != b) begin
            if (a < b) b = b - a;
            else       a = a - b;
        end
        return a;
    endfunction

    function automatic int sub_steps(int a, int b);
        int n = 0;
        while (a != b) begin
            if (a < b) b = b - a;
            else       a = a - b;
            n++;
        end
        return n;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One operation: settle with start low, present operands, run, check
    task automatic run_op(int a, int b);
        int old_res;
        start = 1'b0;
        cyc(5 * sub_steps(prev_a, prev_b) + 20);
        old_res = int'(result);
        opa = W'(a);
        opb = W'(b);
        cyc(30);
        check_eq("R2 start low holds result", int'(result), old_res);
        start = 1'b1;
        cyc(5 * sub_steps(a, b) + 20);
        check_eq("R6 divisor", int'(result), ref_gcd(a, b));
        cyc(5 * sub_steps(a, b) + 15);
        check_eq("R7 stable on repeat", int'(result), ref_gcd(a, b));
        prev_a = a;
        prev_b = b;
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        check_eq("R1 reset clears result", int'(result), 0);
        // R3 latency with equal operands: answer after six edges
        opa = W'(12);
        opb = W'(12);
        start = 1'b1;
        rst_n = 1'b1;
        cyc(5);
        check_eq("R3 not yet after five edges", int'(result), 0);
        cyc(1);
        check_eq("R3 ready after six edges", int'(result), 12);
        // R5 iteration timing: 6,4 takes two iterations (+10 edges)
        start = 1'b0;
        cyc(20);
        rst_n = 1'b0;
        cyc(2);
        check_eq("R1 reset clears again", int'(result), 0);
        opa = W'(6);
        opb = W'(4);
        start = 1'b1;
        rst_n = 1'b1;
        cyc(15);
        check_eq("R5 not yet after 15 edges", int'(result), 0);
        cyc(1);
        check_eq("R5 R4 ready after 16 edges", int'(result), 2);
        prev_a = 6;
        prev_b = 4;
        // Directed corners
        run_op(255, 1);
        run_op(1, 255);
        run_op(200, 200);
        run_op(128, 96);
        run_op(0, 0);
        run_op(221, 17);
        // Seeded random operands, nonzero
        for (int i = 0; i < 30; i++) begin
            run_op(int'($urandom_range(1, 255)), int'($urandom_range(1, 255)));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule